// File: doc/BRIEF.md
# SD Card Data Path Controller

This block is the host-side engine that moves data blocks between local byte FIFOs and an SD or SDIO card over a single data line (DAT0). For a write it pulls bytes from a transmit FIFO and sends each block as one frame: a start bit, the data bits MSB first, a CRC16 and an end bit. It then releases the line and waits for the card's three-bit CRC status token and for the card to finish its busy period. For a read it waits for the card's start bit, shifts the data into bytes, writes them to a receive FIFO and checks the CRC16 of the block. Read and write both continue block by block until the programmed transfer length has been moved.

All line activity advances on card-clock ticks, which are marked by a one-cycle enable. Software-facing logic supplies the direction, the block length, the transfer length and a timeout, and starts a transfer with a rising edge on the enable. Error and completion flags stay set until the next start. Between read blocks the engine can pause in an SDIO read-wait state. Deasserting the enable aborts the transfer at once.

Top module: `sd_dpath`

## Requirements
- R1: After reset the block is idle: `active`, `dat_oe`, `tx_rd`, `rx_wr` and all six flags are 0, and `dat_o` is 1.
- R2: A transfer starts on the clock after `dp_en` rises while idle. `dir_rx`=1 selects a read and 0 a write, and `active` is 1 until the block returns to idle.
- R3: A written block is driven with `dat_oe`=1, one bit per `ck_en` tick: a 0 start bit, then `blk_len`×8 data bits taken MSB first from bytes popped off the transmit FIFO, then 16 CRC bits MSB first, then a 1 end bit. The CRC uses polynomial x^16+x^12+x^5+1 with a zero initial value and covers the data bits only.
- R4: After the end bit the line is released (`dat_oe`=0) and a status token is awaited: a 0 start bit followed by three bits. Token 3'b010 moves to waiting for DAT0 high, the card's not-busy signal. Any other value sets `neg_err` and returns to idle. Once DAT0 is high the next block starts, or, if the transfer length has been sent, `done` is set.
- R5: While the block waits for a status token or a read start bit, `tmo_val`+1 consecutive ticks with DAT0 high set `tmo_err` and return it to idle.
- R6: If the transmit FIFO is empty when a new data byte is needed, `unf_err` is set, the line is released and the block goes idle. No pop is issued on an empty FIFO.
- R7: In a read, a 0 on DAT0 starts a block. Each group of 8 received bits forms a byte, MSB first, and that byte appears on `rx_data` with `rx_wr` high for one clock. The line is never driven during a read.
- R8: The 16 bits after a received block's data are its CRC16 (same polynomial and initial value as R3). On a mismatch `crc_err` is set and the block goes idle.
- R9: If `rx_full` is 1 when a received byte completes, `ovf_err` is set, the byte is not written and the block goes idle.
- R10: When `xfer_len` bytes have been moved, `done` is set and the block returns to idle.
- R11: If `rw_start` and `sdio_en` are both 1 when a received block ends, the block holds in read-wait, with no timeout and no sampling of DAT0, until `rw_stop` is 1. It then waits for the next start bit. With `sdio_en`=0, `rw_start` is ignored.
- R12: When `dp_en` is 0, the block is idle and the line is released on the next clock, and no flag is set by the abort.
- R13: At most one of `done`, `crc_err`, `tmo_err`, `unf_err`, `ovf_err` and `neg_err` is set per transfer. The flags are cleared at a start and otherwise hold their value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ck_en | input | 1 | Card clock tick, one bit per high cycle |
| dp_en | input | 1 | Data path enable, rising edge starts, low aborts |
| dir_rx | input | 1 | 1 = read from card, 0 = write to card |
| sdio_en | input | 1 | SDIO mode, permits read-wait |
| blk_len | input | BLK_W | Bytes per block |
| xfer_len | input | LEN_W | Bytes in the whole transfer |
| tmo_val | input | TMO_W | Timeout in card ticks |
| rw_start | input | 1 | Request read-wait after the current read block |
| rw_stop | input | 1 | Leave read-wait |
| tx_data | input | 8 | Head byte of transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_rd | output | 1 | Pop transmit FIFO |
| rx_data | output | 8 | Byte to receive FIFO |
| rx_wr | output | 1 | Push receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| dat_i | input | 1 | DAT0 line input |
| dat_o | output | 1 | DAT0 line output value |
| dat_oe | output | 1 | DAT0 output enable |
| active | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed |
| crc_err | output | 1 | Received block CRC mismatch |
| tmo_err | output | 1 | Timeout waiting for the card |
| unf_err | output | 1 | Transmit FIFO underrun |
| ovf_err | output | 1 | Receive FIFO overrun |
| neg_err | output | 1 | Negative CRC status token |

## Verification
The bound checker holds several properties on every cycle: disable forces idle with the line released, flags are mutually exclusive and hold while idle, no pop happens on an empty FIFO and no push on a full one, read-wait is held until stop, the line stays released through the card's busy period, and nothing is driven during a read. Other behaviours can only be shown by the bench's card model, which frames and checks whole blocks on DAT0. These are the bit order and CRC16 values, the token decisions, the exact tick on which a timeout fires, the completion after several blocks, and read-wait being honoured only in SDIO mode.

// File: rtl/sd_dpath.sv
module sd_dpath #(
  parameter int BLK_W = 12,
  parameter int LEN_W = 24,
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ck_en,
  input  logic             dp_en,
  input  logic             dir_rx,
  input  logic             sdio_en,
  input  logic [BLK_W-1:0] blk_len,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [TMO_W-1:0] tmo_val,
  input  logic             rw_start,
  input  logic             rw_stop,
  input  logic [7:0]       tx_data,
  input  logic             tx_empty,
  output logic             tx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_wr,
  input  logic             rx_full,
  input  logic             dat_i,
  output logic             dat_o,
  output logic             dat_oe,
  output logic             active,
  output logic             done,
  output logic             crc_err,
  output logic             tmo_err,
  output logic             unf_err,
  output logic             ovf_err,
  output logic             neg_err
);
  localparam int CW = BLK_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_WAITR, S_RECV, S_SEND, S_BUSY, S_WAITS, S_RDWT} st_t;
  typedef enum logic [1:0] {P_HEAD, P_DATA, P_CRC, P_TAIL} ph_t;

  st_t             st;
  ph_t             ph;
  logic [CW-1:0]   cnt;
  logic [7:0]      sh;
  logic [15:0]     crc;
  logic [TMO_W-1:0] tmr;
  logic [LEN_W-1:0] rem;
  logic [1:0]      tok;
  logic            en_q;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h1021 : 16'h0000);
  endfunction

  wire [CW-1:0]    last_bit = CW'({blk_len, 3'b000}) - CW'(1);
  wire             at_last  = (cnt == last_bit);
  wire             start    = (st == S_IDLE) && dp_en && !en_q;
  wire             tx_bit   = (cnt[2:0] == 3'd0) ? tx_data[7] : sh[7];
  wire [7:0]       rx_byte  = {sh[6:0], dat_i};
  wire [LEN_W-1:0] blk_b    = LEN_W'(blk_len);
  wire [LEN_W-1:0] rem_nx   = (rem > blk_b) ? rem - blk_b : '0;
  wire [15:0]      crc_in   = crc_step(crc, (st == S_SEND) ? tx_bit : dat_i);
  wire             tmr_zero = (tmr == '0);
  wire [TMO_W-1:0] tmr_dec  = tmr - TMO_W'(1);

  assign active = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= P_HEAD;  cnt <= '0;  sh <= '0;  crc <= '0;
      tmr <= '0;  rem <= '0;  tok <= '0;  en_q <= 1'b0;
      tx_rd <= 1'b0;  rx_wr <= 1'b0;  rx_data <= '0;
      dat_o <= 1'b1;  dat_oe <= 1'b0;
      done <= 1'b0;  crc_err <= 1'b0;  tmo_err <= 1'b0;
      unf_err <= 1'b0;  ovf_err <= 1'b0;  neg_err <= 1'b0;
    end else begin
      en_q  <= dp_en;
      tx_rd <= 1'b0;
      rx_wr <= 1'b0;
      if (!dp_en) begin
        st <= S_IDLE;  dat_oe <= 1'b0;  dat_o <= 1'b1;
      end else if (start) begin
        done <= 1'b0;  crc_err <= 1'b0;  tmo_err <= 1'b0;
        unf_err <= 1'b0;  ovf_err <= 1'b0;  neg_err <= 1'b0;
        rem <= xfer_len;  tmr <= tmo_val;  ph <= P_HEAD;
        st  <= dir_rx ? S_WAITR : S_SEND;
      end else if (st == S_RDWT) begin
        if (rw_stop) begin
          st <= S_WAITR;  tmr <= tmo_val;
        end
      end else if (ck_en) begin
        case (st)
          S_WAITR: begin
            if (rem == '0) begin
              st <= S_IDLE;  done <= 1'b1;
            end else if (!dat_i) begin
              st <= S_RECV;  ph <= P_DATA;  cnt <= '0;  crc <= '0;
            end else if (tmr_zero) begin
              st <= S_IDLE;  tmo_err <= 1'b1;
            end else tmr <= tmr_dec;
          end
          S_RECV: begin
            case (ph)
              P_DATA: begin
                sh  <= rx_byte;
                crc <= crc_in;
                cnt <= at_last ? '0 : cnt + CW'(1);
                if (at_last) ph <= P_CRC;
                if (cnt[2:0] == 3'd7) begin
                  if (rx_full) begin
                    st <= S_IDLE;  ovf_err <= 1'b1;
                  end else begin
                    rx_data <= rx_byte;  rx_wr <= 1'b1;
                  end
                end
              end
              P_CRC: begin
                crc <= crc_in;
                cnt <= cnt + CW'(1);
                if (cnt == CW'(15)) ph <= P_TAIL;
              end
              default: begin
                if (crc != 16'h0000) begin
                  st <= S_IDLE;  crc_err <= 1'b1;
                end else begin
                  rem <= rem_nx;  tmr <= tmo_val;
                  st  <= (rw_start && sdio_en) ? S_RDWT : S_WAITR;
                end
              end
            endcase
          end
          S_SEND: begin
            case (ph)
              P_HEAD: begin
                dat_o <= 1'b0;  dat_oe <= 1'b1;  ph <= P_DATA;  cnt <= '0;  crc <= '0;
              end
              P_DATA: begin
                if (cnt[2:0] == 3'd0 && tx_empty) begin
                  st <= S_IDLE;  unf_err <= 1'b1;  dat_oe <= 1'b0;  dat_o <= 1'b1;
                end else begin
                  if (cnt[2:0] == 3'd0) begin
                    tx_rd <= 1'b1;  sh <= {tx_data[6:0], 1'b0};
                  end else sh <= {sh[6:0], 1'b0};
                  dat_o <= tx_bit;
                  crc   <= crc_in;
                  cnt   <= at_last ? '0 : cnt + CW'(1);
                  if (at_last) ph <= P_CRC;
                end
              end
              P_CRC: begin
                dat_o <= crc[15];
                crc   <= {crc[14:0], 1'b0};
                cnt   <= cnt + CW'(1);
                if (cnt == CW'(15)) ph <= P_TAIL;
              end
              default: begin
                dat_o <= 1'b1;  st <= S_BUSY;  ph <= P_HEAD;  tmr <= tmo_val;
              end
            endcase
          end
          S_BUSY: begin
            dat_oe <= 1'b0;
            if (ph == P_HEAD) begin
              if (!dat_i) begin
                ph <= P_DATA;  cnt <= '0;
              end else if (tmr_zero) begin
                st <= S_IDLE;  tmo_err <= 1'b1;
              end else tmr <= tmr_dec;
            end else begin
              tok <= {tok[0], dat_i};
              cnt <= cnt + CW'(1);
              if (cnt == CW'(2)) begin
                if ({tok, dat_i} == 3'b010) st <= S_WAITS;
                else begin
                  st <= S_IDLE;  neg_err <= 1'b1;
                end
              end
            end
          end
          S_WAITS: begin
            if (dat_i) begin
              if (rem_nx == '0) begin
                st <= S_IDLE;  done <= 1'b1;
              end else begin
                rem <= rem_nx;  st <= S_SEND;  ph <= P_HEAD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module sd_dpath_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dp_en,
  input logic       rw_stop,
  input logic       tx_rd,
  input logic       tx_empty,
  input logic       rx_wr,
  input logic       rx_full,
  input logic       dat_oe,
  input logic       done,
  input logic       crc_err,
  input logic       tmo_err,
  input logic       unf_err,
  input logic       ovf_err,
  input logic       neg_err,
  input logic [2:0] st
);
  localparam logic [2:0] K_IDLE = 3'd0, K_WAITS = 3'd5, K_RDWT = 3'd6;
  wire [5:0] flags = {done, crc_err, tmo_err, unf_err, ovf_err, neg_err};

  p_disable_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_en |=> (st == K_IDLE && !dat_oe));

  p_flags_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));

  p_flags_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == K_IDLE && !$rose(dp_en)) |=> $stable(flags));

  p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd |-> !$past(tx_empty));

  p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> !$past(rx_full));

  p_rdwait_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == K_RDWT && dp_en && !rw_stop) |=> (st == K_RDWT));

  p_busy_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == K_WAITS) |-> !dat_oe);

  p_rx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> !dat_oe);
endmodule

bind sd_dpath sd_dpath_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dp_en(dp_en), .rw_stop(rw_stop),
  .tx_rd(tx_rd), .tx_empty(tx_empty), .rx_wr(rx_wr), .rx_full(rx_full),
  .dat_oe(dat_oe), .done(done), .crc_err(crc_err), .tmo_err(tmo_err),
  .unf_err(unf_err), .ovf_err(ovf_err), .neg_err(neg_err), .st(st)
);

// File: tb/sim_sd_dpath.sv
`timescale 1ns/1ps
module sim_sd_dpath;
  logic clk = 1'b0, rst_n = 1'b0, ck_en = 1'b0;
  logic dp_en = 1'b0, dir_rx = 1'b0, sdio_en = 1'b0, rw_start = 1'b0, rw_stop = 1'b0;
  logic [3:0] blk_len = 4'd4;
  logic [7:0] xfer_len = 8'd4, tmo_val = 8'd50;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic tx_empty = 1'b1, tx_rd, rx_wr, rx_full = 1'b0, dat_i = 1'b1, dat_o, dat_oe;
  logic active, done, crc_err, tmo_err, unf_err, ovf_err, neg_err;
  logic [1:0] div = 2'd0;
  int vec = 0, bad = 0, wr_cnt = 0;
  logic [7:0] txq[$];
  logic [7:0] exp_q[$];

  sd_dpath #(.BLK_W(4), .LEN_W(8), .TMO_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ck_en(ck_en), .dp_en(dp_en), .dir_rx(dir_rx),
    .sdio_en(sdio_en), .blk_len(blk_len), .xfer_len(xfer_len), .tmo_val(tmo_val),
    .rw_start(rw_start), .rw_stop(rw_stop), .tx_data(tx_data), .tx_empty(tx_empty),
    .tx_rd(tx_rd), .rx_data(rx_data), .rx_wr(rx_wr), .rx_full(rx_full),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe), .active(active), .done(done),
    .crc_err(crc_err), .tmo_err(tmo_err), .unf_err(unf_err), .ovf_err(ovf_err),
    .neg_err(neg_err));

  always #2 clk = ~clk;
  always @(posedge clk) begin
    div   <= div + 2'd1;
    ck_en <= (div == 2'd3);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(logic [15:0] c, logic b);
    return {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic tx_refresh();
    tx_empty = (txq.size() == 0);
    tx_data  = (txq.size() == 0) ? 8'h00 : txq[0];
  endtask

  always @(negedge clk) begin
    if (tx_rd && txq.size() > 0) begin
      void'(txq.pop_front());
      tx_refresh();
    end
  end

  // monitor: pops expected read bytes as the design writes them
  always @(negedge clk) begin
    if (rx_wr) begin
      logic [7:0] e;
      wr_cnt++;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk("R7 read byte", rx_data, e);
    end
  end

  task automatic tick();
    do @(negedge clk); while (!ck_en);
  endtask

  task automatic push_tx(input logic [7:0] b);
    txq.push_back(b);
    exp_q.push_back(b);
    tx_refresh();
  endtask

  task automatic flush();
    txq.delete();
    exp_q.delete();
    tx_refresh();
  endtask

  task automatic start_xfer(input logic rx, input logic [7:0] xl, input logic [7:0] tm);
    @(negedge clk);
    dp_en = 1'b0; dir_rx = rx; blk_len = 4'd4; xfer_len = xl; tmo_val = tm;
    repeat (2) @(negedge clk);
    dp_en = 1'b1;
    @(negedge clk);
    chk("R2 active after start", active, 1);
    chk("R13 flags cleared on start", {done, crc_err, tmo_err, unf_err, ovf_err, neg_err}, 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 6000 && active; i++) @(negedge clk);
  endtask

  // card side of a write: frame check, then token and busy
  task automatic card_wr_block(input bit give_tok, input logic [2:0] tk, input int busy_t);
    int guard = 0;
    logic [15:0] c = 16'h0000, rc = 16'h0000;
    do begin tick(); guard++; end while (!(dat_oe && dat_o == 1'b0) && guard < 2000);
    chk("R3 start bit driven", guard < 2000, 1);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = 8'h00, e;
      for (int j = 0; j < 8; j++) begin
        tick();
        b = {b[6:0], dat_o};
        c = crc_b(c, dat_o);
      end
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk("R3 written byte", b, e);
    end
    for (int k = 0; k < 16; k++) begin
      tick();
      rc = {rc[14:0], dat_o};
    end
    chk("R3 crc16 bits", rc, c);
    tick();
    chk("R3 end bit", {dat_oe, dat_o}, 2'b11);
    if (give_tok) begin
      tick(); dat_i = 1'b0;
      for (int k = 2; k >= 0; k--) begin tick(); dat_i = tk[k]; end
      for (int k = 0; k < busy_t; k++) begin tick(); dat_i = 1'b0; end
      if (busy_t > 0) begin
        chk("R4 line released while card busy", dat_oe, 0);
        chk("R4 still active while card busy", active, 1);
      end
      tick(); dat_i = 1'b1;
    end
  endtask

  // card side of a read: sends one 4-byte block
  task automatic card_rd_block(input logic [31:0] w, input bit bad_crc, input bit expect_wr);
    logic [15:0] c = 16'h0000;
    tick(); dat_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = w[31-8*i -: 8];
      if (expect_wr) exp_q.push_back(b);
      for (int j = 7; j >= 0; j--) begin
        tick(); dat_i = b[j];
        c = crc_b(c, b[j]);
      end
    end
    if (bad_crc) c = c ^ 16'h0001;
    for (int k = 15; k >= 0; k--) begin tick(); dat_i = c[k]; end
    tick(); dat_i = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    #600000;
    bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {active, dat_oe, tx_rd, rx_wr, done, crc_err, tmo_err, unf_err, ovf_err, neg_err, dat_o}, 11'h001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {active, dat_oe, dat_o}, 3'b001);

    // two-block write, positive tokens, busy periods
    for (int i = 0; i < 8; i++) push_tx(8'h31 * i[7:0] + 8'h5A);
    start_xfer(1'b0, 8'd8, 8'd60);
    card_wr_block(1'b1, 3'b010, 3);
    card_wr_block(1'b1, 3'b010, 3);
    wait_idle();
    chk("R10 write done", {done, crc_err, tmo_err, unf_err, ovf_err, neg_err}, 6'b100000);
    chk("R3 all bytes sent", txq.size() + exp_q.size(), 0);
    chk("R4 line released at end", dat_oe, 0);

    // negative token
    for (int i = 0; i < 4; i++) push_tx(8'hC3 ^ i[7:0]);
    start_xfer(1'b0, 8'd4, 8'd60);
    card_wr_block(1'b1, 3'b101, 0);
    wait_idle();
    chk("R4 negative token", {done, neg_err}, 2'b01);

    // write timeout: no token, exact expiry tick
    for (int i = 0; i < 4; i++) push_tx(8'h0F + i[7:0]);
    start_xfer(1'b0, 8'd4, 8'd5);
    card_wr_block(1'b0, 3'b000, 0);
    repeat (5) tick();
    chk("R5 not expired after tmo_val ticks", {active, tmo_err}, 2'b10);
    tick();
    chk("R5 expired on next tick", {active, tmo_err}, 2'b01);

    // underrun: only two bytes available
    flush();
    push_tx(8'hAA); push_tx(8'h55);
    start_xfer(1'b0, 8'd4, 8'd60);
    wait_idle();
    chk("R6 underrun flag", {unf_err, done, dat_oe}, 3'b100);
    flush();

    // two-block read
    w0 = wr_cnt;
    start_xfer(1'b1, 8'd8, 8'd60);
    card_rd_block(32'hA53C0FF1, 1'b0, 1'b1);
    card_rd_block(32'h12807EC9, 1'b0, 1'b1);
    wait_idle();
    chk("R10 read done", {done, crc_err, tmo_err, ovf_err}, 4'b1000);
    chk("R7 bytes written", wr_cnt - w0, 8);
    chk("R7 no byte left over", exp_q.size(), 0);

    // read with corrupted CRC
    start_xfer(1'b1, 8'd4, 8'd60);
    card_rd_block(32'h6611EE99, 1'b1, 1'b1);
    wait_idle();
    chk("R8 crc mismatch", {crc_err, done}, 2'b10);
    flush();

    // overrun
    rx_full = 1'b1;
    w0 = wr_cnt;
    start_xfer(1'b1, 8'd4, 8'd60);
    card_rd_block(32'hDEADBEEF, 1'b0, 1'b0);
    wait_idle();
    chk("R9 overrun flag", {ovf_err, done}, 2'b10);
    chk("R9 no byte written when full", wr_cnt - w0, 0);
    rx_full = 1'b0;

    // read timeout
    start_xfer(1'b1, 8'd4, 8'd6);
    repeat (3) tick();
    chk("R5 read still waiting", {active, tmo_err}, 2'b10);
    wait_idle();
    chk("R5 read timeout", {tmo_err, done}, 2'b10);

    // read-wait in SDIO mode
    sdio_en = 1'b1; rw_start = 1'b1;
    start_xfer(1'b1, 8'd8, 8'd10);
    card_rd_block(32'h01020304, 1'b0, 1'b1);
    repeat (30) tick();
    chk("R11 held in read-wait past timeout", {active, tmo_err}, 2'b10);
    rw_start = 1'b0;
    @(negedge clk); rw_stop = 1'b1;
    @(negedge clk); rw_stop = 1'b0;
    card_rd_block(32'hF0E0D0C0, 1'b0, 1'b1);
    wait_idle();
    chk("R11 resumed and finished", {done, tmo_err}, 2'b10);

    // read-wait request ignored without SDIO mode
    sdio_en = 1'b0; rw_start = 1'b1;
    start_xfer(1'b1, 8'd8, 8'd10);
    card_rd_block(32'h55AA55AA, 1'b0, 1'b1);
    wait_idle();
    chk("R11 no read-wait without sdio_en", {tmo_err, done}, 2'b10);
    rw_start = 1'b0;
    flush();

    // disable mid-write
    for (int i = 0; i < 4; i++) push_tx(8'h77 + i[7:0]);
    start_xfer(1'b0, 8'd4, 8'd60);
    repeat (10) tick();
    chk("R12 driving before abort", dat_oe, 1);
    @(negedge clk); dp_en = 1'b0;
    @(negedge clk);
    chk("R12 idle after disable", {active, dat_oe}, 2'b00);
    chk("R12 no flag on abort", {done, crc_err, tmo_err, unf_err, ovf_err, neg_err}, 0);
    repeat (8) @(negedge clk);
    chk("R13 flags hold while idle", {done, crc_err, tmo_err, unf_err, ovf_err, neg_err}, 0);
    flush();

    summary();
    $finish;
  end
endmodule